// File: doc/BRIEF.md
# Cold-Boot Two-Stage Reset Sequencer

This block turns a power-good indication into two staged reset outputs. After power-good has been seen high for a short debounce interval, the active-low peripheral reset is released. The sequencer then counts a fixed number of host clocks and releases the active-high processor reset. A warm reset follows the same path: power-good drops, then rises again.

Two shared data lines double as configuration straps while the processor reset is asserted. The block latches them on the clock edge at which the processor reset is released. Line 1 is an interrupt-controller enable: high means enabled. Line 0 is an active-low strap that a second processor pulls low to show that it is present. The block stores it inverted, so a stored 1 means a second processor is fitted. The captured bits hold until the next processor-reset release. A done output marks that both resets are released.

All inputs are synchronous to the host clock. A drop of power-good takes effect at the first clock edge that samples it low.

Top module: `rstseq_top`

## Requirements
- R1: While `rst_n` is low, `periph_rst_n` is 0, `cpu_rst` is 1, `seq_done` is 0 and `cfg_bits` is 2'b00.
- R2: `periph_rst_n` goes high at the clock edge that samples `pwr_good` high for the (DEB_CYC+1)-th consecutive time, with DEB_CYC = 16 by default. This is DEB_CYC clocks after the first high sample.
- R3: A single low sample of `pwr_good` before the peripheral release restarts the debounce count from zero.
- R4: `cpu_rst` goes low exactly GAP_CYC clock edges after the edge that released `periph_rst_n`, with GAP_CYC = 66,672 by default. `cpu_rst` is never low while `periph_rst_n` is low.
- R5: At any clock edge that samples `pwr_good` low, `periph_rst_n` becomes 0, `cpu_rst` becomes 1 and `seq_done` becomes 0. Both counts clear, so a later rise runs the full debounce and the full gap again.
- R6: `cfg_bits[1]` takes the value of `strap_lines[1]` sampled at the clock edge where `cpu_rst` falls. A 1 means interrupt controllers are enabled.
- R7: `cfg_bits[0]` takes the inverse of `strap_lines[0]` sampled at that same edge. A low line gives 1, which means a second processor is present.
- R8: `cfg_bits` changes at no other edge. Strap changes and power-good drops leave it unchanged.
- R9: `seq_done` is 1 exactly when `periph_rst_n` is 1 and `cpu_rst` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pwr_good | input | 1 | Power-good indication, synchronous to clk |
| strap_lines | input | 2 | Sampled levels of the shared data lines (bit 1: enable strap, bit 0: active-low second-processor strap) |
| periph_rst_n | output | 1 | Active-low peripheral reset |
| cpu_rst | output | 1 | Active-high processor reset |
| cfg_bits | output | 2 | Captured straps: bit 1 interrupt-controller enable, bit 0 second processor present |
| seq_done | output | 1 | Both resets released |

## Verification
The bench drives short power-good glitches inside the debounce window. A design that failed to restart its count would release the peripheral reset too early. It measures the processor release against the peripheral release to the exact clock, which catches an off-by-one in the gap compare. It also aborts one sequence deep inside the gap; a counter that did not clear would then release the second run early.

The straps change at random on every clock, and forced values are set on the capture edge itself. A latch one edge early or late, a missing inversion on line 0, or bits that follow the lines after the release all show up as a wrong `cfg_bits`.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;

  typedef enum logic [1:0] {
    SEQ_OFF    = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_GAP    = 2'd2,
    SEQ_RUN    = 2'd3
  } seq_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rstseq_counter.sv
`timescale 1ns/1ps
module rstseq_counter #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/rstseq_fsm.sv
`timescale 1ns/1ps
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int unsigned DEB_CYC = 16,
  parameter int unsigned GAP_CYC = 66672,
  parameter int unsigned CNT_W   = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             cnt_en,
  output logic             capture,
  output logic             periph_rst_n,
  output logic             cpu_rst,
  output logic             seq_done
);

  localparam logic [CNT_W-1:0] DEB_LAST = CNT_W'(DEB_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    capture = 1'b0;
    if (!pwr_good) begin
      state_d = SEQ_OFF;
      cnt_clr = 1'b1;
    end else begin
      unique case (state_q)
        SEQ_OFF: begin
          state_d = SEQ_SETTLE;
          cnt_clr = 1'b1;
        end
        SEQ_SETTLE: begin
          if (cnt == DEB_LAST) begin
            state_d = SEQ_GAP;
            cnt_clr = 1'b1;
          end else begin
            cnt_en = 1'b1;
          end
        end
        SEQ_GAP: begin
          if (cnt == GAP_LAST) begin
            state_d = SEQ_RUN;
            cnt_clr = 1'b1;
            capture = 1'b1;
          end else begin
            cnt_en = 1'b1;
          end
        end
        SEQ_RUN: begin
          state_d = SEQ_RUN;
        end
        default: begin
          state_d = SEQ_OFF;
          cnt_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SEQ_OFF;
      periph_rst_n <= 1'b0;
      cpu_rst      <= 1'b1;
      seq_done     <= 1'b0;
    end else begin
      state_q      <= state_d;
      periph_rst_n <= (state_d == SEQ_GAP) || (state_d == SEQ_RUN);
      cpu_rst      <= (state_d != SEQ_RUN);
      seq_done     <= (state_d == SEQ_RUN);
    end
  end

endmodule

// File: rtl/rstseq_strap_latch.sv
`timescale 1ns/1ps
module rstseq_strap_latch #(
  parameter int unsigned      NUM_STRAPS = 2,
  parameter logic [NUM_STRAPS-1:0] INV_MASK = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  capture,
  input  logic [NUM_STRAPS-1:0] lines,
  output logic [NUM_STRAPS-1:0] bits
);

  for (genvar g = 0; g < NUM_STRAPS; g++) begin : g_strap
    logic bit_d;

    if (INV_MASK[g]) begin : g_inv
      assign bit_d = capture ? ~lines[g] : bits[g];
    end else begin : g_pass
      assign bit_d = capture ? lines[g] : bits[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bits[g] <= 1'b0;
      end else begin
        bits[g] <= bit_d;
      end
    end
  end

endmodule

// File: rtl/rstseq_top.sv
`timescale 1ns/1ps
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int unsigned DEB_CYC    = 16,
  parameter int unsigned GAP_CYC    = 66672,
  parameter int unsigned NUM_STRAPS = 2,
  parameter logic [NUM_STRAPS-1:0] STRAP_INV = 2'b01
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwr_good,
  input  logic [NUM_STRAPS-1:0] strap_lines,
  output logic                  periph_rst_n,
  output logic                  cpu_rst,
  output logic [NUM_STRAPS-1:0] cfg_bits,
  output logic                  seq_done
);

  localparam int unsigned CNT_W = $clog2(max_u(DEB_CYC, GAP_CYC) + 1);

  logic [CNT_W-1:0] cnt;
  logic             cnt_clr;
  logic             cnt_en;
  logic             capture;

  rstseq_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .cnt   (cnt)
  );

  rstseq_fsm #(
    .DEB_CYC (DEB_CYC),
    .GAP_CYC (GAP_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .cnt          (cnt),
    .cnt_clr      (cnt_clr),
    .cnt_en       (cnt_en),
    .capture      (capture),
    .periph_rst_n (periph_rst_n),
    .cpu_rst      (cpu_rst),
    .seq_done     (seq_done)
  );

  rstseq_strap_latch #(
    .NUM_STRAPS (NUM_STRAPS),
    .INV_MASK   (STRAP_INV)
  ) u_strap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .lines   (strap_lines),
    .bits    (cfg_bits)
  );

endmodule

// File: rtl/rstseq_chk.sv
`timescale 1ns/1ps
module rstseq_chk #(
  parameter int unsigned DEB_CYC    = 16,
  parameter int unsigned GAP_CYC    = 66672,
  parameter int unsigned NUM_STRAPS = 2,
  parameter logic [NUM_STRAPS-1:0] STRAP_INV = 2'b01
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pwr_good,
  input logic [NUM_STRAPS-1:0] strap_lines,
  input logic                  periph_rst_n,
  input logic                  cpu_rst,
  input logic [NUM_STRAPS-1:0] cfg_bits,
  input logic                  seq_done
);

  logic [31:0] hi_run;
  logic [31:0] gap_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run  <= '0;
      gap_run <= '0;
    end else begin
      if (!pwr_good) begin
        hi_run <= '0;
      end else if (hi_run != 32'hFFFF_FFFF) begin
        hi_run <= hi_run + 32'd1;
      end
      if (!periph_rst_n) begin
        gap_run <= '0;
      end else if (cpu_rst && gap_run != 32'hFFFF_FFFF) begin
        gap_run <= gap_run + 32'd1;
      end
    end
  end

  AST_DEBOUNCE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periph_rst_n) |-> (hi_run == DEB_CYC + 32'd1)); // R2

  AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rst |-> periph_rst_n); // R4

  AST_GAP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst) |-> (gap_run == GAP_CYC)); // R4

  AST_PG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!periph_rst_n && cpu_rst && !seq_done)); // R5

  AST_STRAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst) |-> (cfg_bits == ($past(strap_lines) ^ STRAP_INV))); // R6

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cpu_rst) |-> $stable(cfg_bits)); // R8

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done == (periph_rst_n && !cpu_rst)); // R9

endmodule

bind rstseq_top rstseq_chk #(
  .DEB_CYC    (DEB_CYC),
  .GAP_CYC    (GAP_CYC),
  .NUM_STRAPS (NUM_STRAPS),
  .STRAP_INV  (STRAP_INV)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_good     (pwr_good),
  .strap_lines  (strap_lines),
  .periph_rst_n (periph_rst_n),
  .cpu_rst      (cpu_rst),
  .cfg_bits     (cfg_bits),
  .seq_done     (seq_done)
);

// File: tb/test_rstseq_top.sv
`timescale 1ns/1ps
module test_rstseq_top;

  localparam int DEB = 16;
  localparam int GAP = 66672;

  logic       clk;
  logic       rst_n;
  logic       pwr_good;
  logic [1:0] strap_lines;
  logic       periph_rst_n;
  logic       cpu_rst;
  logic [1:0] cfg_bits;
  logic       seq_done;

  rstseq_top i_rstseq_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .strap_lines  (strap_lines),
    .periph_rst_n (periph_rst_n),
    .cpu_rst      (cpu_rst),
    .cfg_bits     (cfg_bits),
    .seq_done     (seq_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // reference model state
  int         m_hi   = 0;
  int         m_gap  = 0;
  bit         m_per  = 0;
  bit         m_cpu  = 1;
  logic [1:0] m_cfg  = 2'b00;

  function automatic logic [1:0] map_straps(input logic [1:0] sl);
    return {sl[1], ~sl[0]};
  endfunction

  function automatic logic [4:0] exp_vec();
    return {m_per, m_cpu, (m_per && !m_cpu), m_cfg};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_edge(input logic pg, input logic [1:0] sl);
    if (!pg) begin
      m_hi = 0; m_gap = 0; m_per = 0; m_cpu = 1;
    end else begin
      m_hi++;
      if (!m_per) begin
        if (m_hi == DEB + 1) begin m_per = 1; m_gap = 0; end
      end else if (m_cpu) begin
        m_gap++;
        if (m_gap == GAP) begin m_cpu = 0; m_cfg = map_straps(sl); end
      end
    end
  endtask

  // one clock: drive, edge, model, compare every output (R2 R4 R5 R6 R7 R8 R9)
  task automatic step(input logic pg, input logic [1:0] sl);
    logic [4:0] act;
    pwr_good    = pg;
    strap_lines = sl;
    @(posedge clk);
    model_edge(pg, sl);
    cyc++;
    @(negedge clk);
    act = {periph_rst_n, cpu_rst, seq_done, cfg_bits};
    chk(act == exp_vec(), "R2 R4 R5 R6 R7 R8 R9 cycle model", int'(act), int'(exp_vec()));
  endtask

  task automatic full_seq(input logic [1:0] forced);
    int e0, r0;
    logic [1:0] sl;
    step(1'b1, 2'($urandom));
    e0 = cyc;
    for (int i = 0; i < DEB + 4 && !periph_rst_n; i++) step(1'b1, 2'($urandom));
    chk(cyc - e0 == DEB, "R2 debounce length", cyc - e0, DEB);
    chk(cpu_rst == 1'b1, "R4 cpu held after periph release", int'(cpu_rst), 1);
    r0 = cyc;
    for (int i = 0; i < GAP + 4 && cpu_rst; i++) begin
      sl = (m_gap == GAP - 1) ? forced : 2'($urandom);
      step(1'b1, sl);
    end
    chk(cyc - r0 == GAP, "R4 release gap", cyc - r0, GAP);
    chk(cfg_bits[1] == forced[1], "R6 enable strap", int'(cfg_bits[1]), int'(forced[1]));
    chk(cfg_bits[0] == ~forced[0], "R7 dual strap inverted", int'(cfg_bits[0]), int'(~forced[0]));
    chk(seq_done == 1'b1, "R9 done after both released", int'(seq_done), 1);
  endtask

  initial begin
    logic [1:0] held;
    int n;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    pwr_good = 1'b0;
    strap_lines = 2'b00;
    repeat (3) @(negedge clk);
    chk({periph_rst_n, cpu_rst, seq_done, cfg_bits} == 5'b01000, "R1 reset state",
        int'({periph_rst_n, cpu_rst, seq_done, cfg_bits}), 8);
    rst_n = 1'b1;
    step(1'b0, 2'b11);
    step(1'b0, 2'b00);

    // glitches inside the debounce window
    for (int t = 0; t < 20; t++) begin
      n = $urandom_range(1, DEB - 1);
      for (int k = 0; k < n; k++) step(1'b1, 2'($urandom));
      step(1'b0, 2'($urandom));
      chk(periph_rst_n == 1'b0, "R3 glitch restarts debounce", int'(periph_rst_n), 0);
    end
    // exactly DEB high samples, then low: must not release
    for (int k = 0; k < DEB; k++) step(1'b1, 2'($urandom));
    chk(periph_rst_n == 1'b0, "R2 no release before count", int'(periph_rst_n), 0);
    step(1'b0, 2'b00);

    full_seq(2'b10);
    held = cfg_bits;
    chk(held == 2'b11, "R6 R7 first capture", int'(held), 3);
    for (int k = 0; k < 60; k++) step(1'b1, 2'($urandom));
    chk(cfg_bits == held, "R8 hold after release", int'(cfg_bits), int'(held));

    step(1'b0, 2'b01);
    chk({periph_rst_n, cpu_rst, seq_done} == 3'b010, "R5 drop after run",
        int'({periph_rst_n, cpu_rst, seq_done}), 2);
    chk(cfg_bits == held, "R8 hold across drop", int'(cfg_bits), int'(held));

    // abort inside gap
    for (int k = 0; k < DEB + 1; k++) step(1'b1, 2'($urandom));
    chk(periph_rst_n == 1'b1, "R2 second release", int'(periph_rst_n), 1);
    n = $urandom_range(100, 2000);
    for (int k = 0; k < n; k++) step(1'b1, 2'($urandom));
    step(1'b0, 2'($urandom));
    chk({periph_rst_n, cpu_rst, seq_done} == 3'b010, "R5 drop inside gap",
        int'({periph_rst_n, cpu_rst, seq_done}), 2);
    chk(cfg_bits == held, "R8 hold after abort", int'(cfg_bits), int'(held));

    full_seq(2'b01);
    chk(cfg_bits == 2'b00, "R6 R7 second capture", int'(cfg_bits), 0);

    for (int k = 0; k < 10; k++) step(1'b0, 2'($urandom));
    chk(seq_done == 1'b0, "R9 done clears on drop", int'(seq_done), 0);
    chk(cfg_bits == 2'b00, "R8 hold while off", int'(cfg_bits), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(195000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule